// File: doc/BRIEF.md
# Multi-port MDIO management slave

This block is the serial management slave of an eight-port device. It is clocked by the management clock and samples the data line on each rising edge. It parses clause-22 style frames: a run of ones, a start pattern, an opcode, a PHY address, a register address, a turnaround and sixteen data bits. One slave answers on eight consecutive PHY addresses. The addresses start at a base taken from strap pins, and each port has its own small file of 16-bit registers.

Writes land in the addressed port's register. Reads are driven back on the line through an output enable, with the data changed just after a rising edge so that the controller can sample it on the next one. A disable input turns the whole interface off. An alternate strap mode limits the base to multiples of eight. Any frame with a bad start pattern, a bad opcode or an address that no port claims is dropped without driving the line. After that the slave needs a fresh run of 32 ones before it will take another frame.

The interface is a single-bit serial line with no back-pressure. Every bit cell is consumed on its clock edge, so there is no valid/ready handshake.

Top module: `mdio_mgmt_slave`

## Requirements
- R1: After reset the output enable is low and every implemented register of every port reads back as 0x0000.
- R2: A frame is 32 or more ones, then start bits 0,1, then a 2-bit opcode (1,0 = read; 0,1 = write), a 5-bit PHY address and a 5-bit register address, all MSB first. A write frame carries turnaround bits 1,0 and then 16 data bits MSB first, and a later read of the same port and register returns those data.
- R3: In a read, the slave leaves the first turnaround cell undriven and drives 0 in the second. It then drives D15 down to D0, one per cell, and releases the line in the cell after D0.
- R4: Port p (0 to 7) answers on PHY address (base + p) mod 32, and each port keeps a separate register file.
- R5: In normal strap mode the base is the 5-bit strap value. In alternate mode the base is strap[4:3] times 8, and strap[2:0] has no effect.
- R6: A frame whose PHY address matches no port is never driven (read) and never stored (write).
- R7: A start pattern other than 0,1, or an opcode of 0,0 or 1,1, abandons the frame: nothing is driven and nothing is stored.
- R8: A frame preceded by only 31 ones (after a 0) is ignored: nothing is driven and nothing is stored.
- R9: While the disable input is high, no frame is driven or stored. Once it is low again, frames are accepted.
- R10: Registers 0 to 7 are implemented. A read of register 8 to 31 returns 0x0000, and a write to one of them is discarded and changes no implemented register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mdc | input | 1 | Management clock; all state moves on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mgmt_disable | input | 1 | High turns the interface off and returns the parser to idle |
| strap_base | input | 5 | Strapped base PHY address |
| strap_alt | input | 1 | High selects the alternate base mode (low three base bits forced to 0) |
| mdio_i | input | 1 | Sampled value of the management data line |
| mdio_o | output | 1 | Value driven on the data line during a read |
| mdio_oe | output | 1 | High when the slave drives the data line |

## Verification
Let edge k be the rising edge that samples the last register-address bit. The bench then expects the enable to be low in the cell after edge k, to be high with 0 in the cell after edge k+1, to carry D15 through D0 in the cells after edges k+2 to k+17, and to be low again after edge k+18. It samples every cell on the falling edge, halfway between the edge that sets the value and the edge where the controller would sample it. A write is stored on the edge that samples D0, so the bench always confirms it with a later read frame rather than by looking inside. Frames that must have no effect are followed by a read of the register they could have changed, and for dropped reads the bench watches that the enable never rises.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  typedef enum logic [2:0] {
    S_PRE, S_ST, S_OP, S_PHY, S_REG, S_TA, S_DAT
  } fstate_t;

  localparam logic [1:0] OP_RD = 2'b10;
  localparam logic [1:0] OP_WR = 2'b01;
endpackage

// File: rtl/mdio_addr_match.sv
module mdio_addr_match #(
  parameter int NPORTS = 8,
  parameter int AW = 5,
  parameter int ALT_ZERO_BITS = 3,
  localparam int PW = $clog2(NPORTS)
) (
  input  logic [AW-1:0] strap_base,
  input  logic          strap_alt,
  input  logic [AW-1:0] addr,
  output logic          hit,
  output logic [PW-1:0] port
);
  logic [AW-1:0]     base;
  logic [NPORTS-1:0] hv;

  assign base = strap_alt ? {strap_base[AW-1:ALT_ZERO_BITS], {ALT_ZERO_BITS{1'b0}}}
                          : strap_base;

  // one comparator per port, address wraps modulo 2^AW
  for (genvar p = 0; p < NPORTS; p++) begin : g_cmp
    assign hv[p] = (addr == AW'(base + AW'(p)));
  end

  always_comb begin
    port = '0;
    for (int p = 0; p < NPORTS; p++) begin
      if (hv[p]) port = PW'(p);
    end
  end

  assign hit = |hv;
endmodule

// File: rtl/mdio_regfile.sv
module mdio_regfile #(
  parameter int NPORTS = 8,
  parameter int NREGS_IMPL = 8,
  parameter int RAW = 5,
  parameter int DW = 16,
  localparam int PW = $clog2(NPORTS),
  localparam int IW = $clog2(NREGS_IMPL)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           we,
  input  logic [PW-1:0]  port,
  input  logic [RAW-1:0] regn,
  input  logic [DW-1:0]  wdata,
  output logic [DW-1:0]  rdata
);
  logic [DW-1:0] mem [NPORTS][NREGS_IMPL];
  logic          in_range;

  assign in_range = (regn < RAW'(NREGS_IMPL));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int p = 0; p < NPORTS; p++) begin
        for (int r = 0; r < NREGS_IMPL; r++) begin
          mem[p][r] <= '0;
        end
      end
    end else if (we && in_range) begin
      mem[port][regn[IW-1:0]] <= wdata;
    end
  end

  assign rdata = in_range ? mem[port][regn[IW-1:0]] : '0;
endmodule

// File: rtl/mdio_frame_fsm.sv
module mdio_frame_fsm
  import mdio_pkg::*;
#(
  parameter int AW = 5,
  parameter int RAW = 5,
  parameter int DW = 16,
  parameter int PW = 3,
  parameter int PRE_LEN = 32,
  localparam int BCW = $clog2(DW),
  localparam int PCW = $clog2(PRE_LEN + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           dis,
  input  logic           mdio_i,
  input  logic           hit,
  input  logic [PW-1:0]  hit_port,
  input  logic [DW-1:0]  rd_data,
  output logic [AW-1:0]  cand_addr,
  output logic [PW-1:0]  port_q,
  output logic [RAW-1:0] reg_q,
  output logic           we,
  output logic [DW-1:0]  wdata,
  output logic           oe_q,
  output logic           o_q,
  output logic           is_rd
);
  fstate_t        st;
  logic [PCW-1:0] pcnt;
  logic [BCW-1:0] bcnt;
  logic [DW-2:0]  sh;
  logic [DW-1:0]  rd_sh;

  assign cand_addr = {sh[AW-2:0], mdio_i};
  assign wdata     = {sh[DW-2:0], mdio_i};
  assign we        = (st == S_DAT) && (bcnt == BCW'(DW-1)) && !is_rd && !dis;

  always_ff @(posedge clk) begin
    if (!rst_n || dis) begin
      st     <= S_PRE;
      pcnt   <= '0;
      bcnt   <= '0;
      sh     <= '0;
      is_rd  <= 1'b0;
      port_q <= '0;
      reg_q  <= '0;
      oe_q   <= 1'b0;
      o_q    <= 1'b0;
      rd_sh  <= '0;
    end else begin
      sh <= {sh[DW-3:0], mdio_i};
      case (st)
        S_PRE: begin
          if (mdio_i) begin
            if (pcnt != PCW'(PRE_LEN)) pcnt <= pcnt + 1'b1;
          end else if (pcnt == PCW'(PRE_LEN)) begin
            st <= S_ST;
          end else begin
            pcnt <= '0;
          end
        end
        S_ST: begin
          bcnt <= '0;
          pcnt <= '0;
          st   <= mdio_i ? S_OP : S_PRE;
        end
        S_OP: begin
          bcnt <= bcnt + 1'b1;
          if (bcnt == BCW'(1)) begin
            bcnt <= '0;
            if ({sh[0], mdio_i} == OP_RD) begin
              is_rd <= 1'b1;
              st    <= S_PHY;
            end else if ({sh[0], mdio_i} == OP_WR) begin
              is_rd <= 1'b0;
              st    <= S_PHY;
            end else begin
              st <= S_PRE;
            end
          end
        end
        S_PHY: begin
          bcnt <= bcnt + 1'b1;
          if (bcnt == BCW'(AW-1)) begin
            bcnt <= '0;
            if (hit) begin
              port_q <= hit_port;
              st     <= S_REG;
            end else begin
              st <= S_PRE;
            end
          end
        end
        S_REG: begin
          bcnt <= bcnt + 1'b1;
          if (bcnt == BCW'(RAW-1)) begin
            bcnt  <= '0;
            reg_q <= {sh[RAW-2:0], mdio_i};
            st    <= S_TA;
          end
        end
        S_TA: begin
          if (bcnt == '0) begin
            bcnt <= bcnt + 1'b1;
            if (is_rd) begin
              oe_q  <= 1'b1;
              o_q   <= 1'b0;
              rd_sh <= rd_data;
            end
          end else begin
            bcnt <= '0;
            st   <= S_DAT;
            if (is_rd) begin
              o_q   <= rd_sh[DW-1];
              rd_sh <= {rd_sh[DW-2:0], 1'b0};
            end
          end
        end
        S_DAT: begin
          bcnt <= bcnt + 1'b1;
          if (bcnt == BCW'(DW-1)) begin
            bcnt <= '0;
            oe_q <= 1'b0;
            o_q  <= 1'b0;
            st   <= S_PRE;
          end else if (is_rd) begin
            o_q   <= rd_sh[DW-1];
            rd_sh <= {rd_sh[DW-2:0], 1'b0};
          end
        end
        default: st <= S_PRE;
      endcase
    end
  end
endmodule

// File: rtl/mdio_mgmt_slave.sv
module mdio_mgmt_slave #(
  parameter int NPORTS = 8,
  parameter int AW = 5,
  parameter int RAW = 5,
  parameter int DW = 16,
  parameter int NREGS_IMPL = 8,
  parameter int PRE_LEN = 32,
  parameter int ALT_ZERO_BITS = 3,
  localparam int PW = $clog2(NPORTS)
) (
  input  logic          mdc,
  input  logic          rst_n,
  input  logic          mgmt_disable,
  input  logic [AW-1:0] strap_base,
  input  logic          strap_alt,
  input  logic          mdio_i,
  output logic          mdio_o,
  output logic          mdio_oe
);
  logic [AW-1:0]  cand_addr;
  logic           hit;
  logic [PW-1:0]  hit_port;
  logic [PW-1:0]  port_q;
  logic [RAW-1:0] reg_q;
  logic           reg_we;
  logic [DW-1:0]  wdata;
  logic [DW-1:0]  rdata;
  logic           oe_q;
  logic           is_rd;

  mdio_addr_match #(
    .NPORTS(NPORTS), .AW(AW), .ALT_ZERO_BITS(ALT_ZERO_BITS)
  ) u_match (
    .strap_base(strap_base),
    .strap_alt (strap_alt),
    .addr      (cand_addr),
    .hit       (hit),
    .port      (hit_port)
  );

  mdio_frame_fsm #(
    .AW(AW), .RAW(RAW), .DW(DW), .PW(PW), .PRE_LEN(PRE_LEN)
  ) u_fsm (
    .clk      (mdc),
    .rst_n    (rst_n),
    .dis      (mgmt_disable),
    .mdio_i   (mdio_i),
    .hit      (hit),
    .hit_port (hit_port),
    .rd_data  (rdata),
    .cand_addr(cand_addr),
    .port_q   (port_q),
    .reg_q    (reg_q),
    .we       (reg_we),
    .wdata    (wdata),
    .oe_q     (oe_q),
    .o_q      (mdio_o),
    .is_rd    (is_rd)
  );

  mdio_regfile #(
    .NPORTS(NPORTS), .NREGS_IMPL(NREGS_IMPL), .RAW(RAW), .DW(DW)
  ) u_regs (
    .clk  (mdc),
    .rst_n(rst_n),
    .we   (reg_we),
    .port (port_q),
    .regn (reg_q),
    .wdata(wdata),
    .rdata(rdata)
  );

  assign mdio_oe = oe_q & ~mgmt_disable;
endmodule

// File: rtl/mdio_mgmt_slave_chk.sv
module mdio_mgmt_slave_chk (
  input logic mdc,
  input logic rst_n,
  input logic dis,
  input logic oe,
  input logic o,
  input logic is_rd,
  input logic we
);
  logic [4:0] oe_run;

  always_ff @(posedge mdc) begin
    if (!rst_n) oe_run <= '0;
    else        oe_run <= oe ? oe_run + 1'b1 : '0;
  end

  // R3
  ta_zero_chk: assert property (@(posedge mdc) disable iff (!rst_n)
    $rose(oe) |-> !o);

  // R3
  drive_len_chk: assert property (@(posedge mdc) disable iff (!rst_n)
    oe |-> (oe_run < 5'd17));

  // R2
  drive_read_only_chk: assert property (@(posedge mdc) disable iff (!rst_n)
    oe |-> is_rd);

  // R2
  no_store_while_drive_chk: assert property (@(posedge mdc) disable iff (!rst_n)
    we |-> !oe);

  // R9
  disabled_quiet_chk: assert property (@(posedge mdc) disable iff (!rst_n)
    (dis && $past(dis)) |-> (!we && !oe));
endmodule

bind mdio_mgmt_slave mdio_mgmt_slave_chk u_chk (
  .mdc  (mdc),
  .rst_n(rst_n),
  .dis  (mgmt_disable),
  .oe   (mdio_oe),
  .o    (mdio_o),
  .is_rd(is_rd),
  .we   (reg_we)
);

// File: tb/mdio_mgmt_slave_tb.sv
module mdio_mgmt_slave_tb;
  logic       mdc = 1'b0;
  logic       rst_n = 1'b0;
  logic       dis = 1'b0;
  logic [4:0] strap = 5'd0;
  logic       alt = 1'b0;
  logic       h_en = 1'b0;
  logic       h_bit = 1'b1;
  logic       mdio_o, mdio_oe, line;

  int n_chk = 0;
  int n_fail = 0;
  logic [15:0] model [8][32];

  always #5 mdc = ~mdc;

  assign line = mdio_oe ? mdio_o : (h_en ? h_bit : 1'b1);

  mdio_mgmt_slave u_dut (
    .mdc(mdc), .rst_n(rst_n), .mgmt_disable(dis), .strap_base(strap),
    .strap_alt(alt), .mdio_i(line), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int port_idx(input logic [4:0] phy);
    logic [4:0] b;
    logic [4:0] d;
    b = alt ? {strap[4:3], 3'b000} : strap;
    d = phy - b;
    return (d < 5'd8) ? int'(d) : -1;
  endfunction

  function automatic logic [15:0] exp_read(input logic [4:0] phy, input logic [4:0] ra);
    int p;
    p = port_idx(phy);
    if (p < 0 || ra >= 5'd8) return 16'h0000;
    return model[p][ra];
  endfunction

  task automatic model_write(input logic [4:0] phy, input logic [4:0] ra, input logic [15:0] wd);
    int p;
    p = port_idx(phy);
    if (p >= 0 && ra < 5'd8) model[p][ra] = wd;
  endtask

  task automatic put(input bit b);
    @(negedge mdc);
    h_en = 1'b1;
    h_bit = b;
    @(posedge mdc);
  endtask

  task automatic frame(input int pre, input logic [1:0] stb, input logic [1:0] op,
                       input logic [4:0] phy, input logic [4:0] ra, input logic [15:0] wd,
                       output logic [15:0] rd, output bit ta_ok, output bit drove);
    bit w0, ta1, dok, rel;
    rd = '0; ta_ok = 0; drove = 0;
    put(0); put(0);
    repeat (pre) put(1);
    put(stb[1]); put(stb[0]);
    put(op[1]); put(op[0]);
    for (int i = 4; i >= 0; i--) put(phy[i]);
    for (int i = 4; i >= 0; i--) put(ra[i]);
    if (op == 2'b10) begin
      @(negedge mdc); h_en = 1'b0; w0 = mdio_oe; drove = mdio_oe; @(posedge mdc);
      @(negedge mdc); ta1 = mdio_oe && !mdio_o; drove |= mdio_oe; @(posedge mdc);
      dok = 1;
      for (int k = 15; k >= 0; k--) begin
        @(negedge mdc); rd[k] = mdio_o; dok &= mdio_oe; drove |= mdio_oe; @(posedge mdc);
      end
      @(negedge mdc); rel = !mdio_oe; drove |= mdio_oe; @(posedge mdc);
      ta_ok = !w0 && ta1 && dok && rel;
    end else begin
      put(1); put(0);
      for (int i = 15; i >= 0; i--) put(wd[i]);
    end
    @(negedge mdc); h_en = 1'b0;
  endtask

  task automatic wr(input logic [4:0] phy, input logic [4:0] ra, input logic [15:0] wd);
    logic [15:0] r; bit t, d;
    frame(32, 2'b01, 2'b01, phy, ra, wd, r, t, d);
  endtask

  task automatic rd_chk(input string req, input logic [4:0] phy, input logic [4:0] ra);
    logic [15:0] r; bit t, d;
    frame(32, 2'b01, 2'b10, phy, ra, 16'h0, r, t, d);
    if (port_idx(phy) >= 0) begin
      chk(t, req, {31'd0, t}, 32'd1);
      chk(r == exp_read(phy, ra), req, {16'd0, r}, {16'd0, exp_read(phy, ra)});
    end else begin
      chk(!d, req, {31'd0, d}, 32'd0);
    end
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] r; bit t, d;
    int unsigned seed_v;
    seed_v = $urandom(32'h00C0FFEE);
    for (int p = 0; p < 8; p++) for (int q = 0; q < 32; q++) model[p][q] = 16'h0;
    repeat (4) @(posedge mdc);
    @(negedge mdc);
    // R1: reset state
    chk(!mdio_oe, "R1", {31'd0, mdio_oe}, 32'd0);
    rst_n = 1'b1;
    rd_chk("R1", 5'd0, 5'd0);
    rd_chk("R1", 5'd7, 5'd7);

    // R2/R3: write then read back with turnaround checks
    strap = 5'd4;
    wr(5'd4, 5'd3, 16'hA5C3); model_write(5'd4, 5'd3, 16'hA5C3);
    rd_chk("R2", 5'd4, 5'd3);
    wr(5'd5, 5'd0, 16'h8001); model_write(5'd5, 5'd0, 16'h8001);
    rd_chk("R3", 5'd5, 5'd0);

    // R4: separate ports, top port
    wr(5'd11, 5'd3, 16'h1234); model_write(5'd11, 5'd3, 16'h1234);
    rd_chk("R4", 5'd4, 5'd3);
    rd_chk("R4", 5'd11, 5'd3);

    // R6: unmatched address
    wr(5'd12, 5'd3, 16'hDEAD);
    rd_chk("R6", 5'd12, 5'd3);
    rd_chk("R6", 5'd3, 5'd3);
    rd_chk("R6", 5'd11, 5'd3);

    // R4: wrap modulo 32
    strap = 5'd28;
    rd_chk("R4", 5'd3, 5'd3);

    // R5: alternate mode ignores low strap bits
    alt = 1'b1; strap = 5'b10111;
    rd_chk("R5", 5'd23, 5'd3);
    rd_chk("R5", 5'd16, 5'd3);
    rd_chk("R5", 5'd24, 5'd3);
    alt = 1'b0;
    rd_chk("R5", 5'd23, 5'd0);

    // R10: unimplemented registers
    strap = 5'd0;
    wr(5'd0, 5'd20, 16'hFFFF);
    rd_chk("R10", 5'd0, 5'd20);
    rd_chk("R10", 5'd0, 5'd4);
    rd_chk("R10", 5'd0, 5'd12);

    // R7: bad opcodes and bad start
    frame(32, 2'b01, 2'b11, 5'd0, 5'd1, 16'h5555, r, t, d);
    frame(32, 2'b01, 2'b00, 5'd0, 5'd1, 16'h6666, r, t, d);
    frame(32, 2'b00, 2'b01, 5'd0, 5'd1, 16'h7777, r, t, d);
    rd_chk("R7", 5'd0, 5'd1);
    frame(32, 2'b00, 2'b10, 5'd0, 5'd1, 16'h0, r, t, d);
    chk(!d, "R7", {31'd0, d}, 32'd0);

    // R8: short preamble
    frame(31, 2'b01, 2'b01, 5'd0, 5'd2, 16'h4321, r, t, d);
    rd_chk("R8", 5'd0, 5'd2);
    frame(31, 2'b01, 2'b10, 5'd0, 5'd2, 16'h0, r, t, d);
    chk(!d, "R8", {31'd0, d}, 32'd0);

    // R9: disabled interface
    dis = 1'b1;
    wr(5'd1, 5'd1, 16'hBEEF);
    frame(32, 2'b01, 2'b10, 5'd1, 5'd1, 16'h0, r, t, d);
    chk(!d, "R9", {31'd0, d}, 32'd0);
    dis = 1'b0;
    rd_chk("R9", 5'd1, 5'd1);
    wr(5'd1, 5'd1, 16'hBEEF); model_write(5'd1, 5'd1, 16'hBEEF);
    rd_chk("R9", 5'd1, 5'd1);

    // random mix (R2, R4, R5, R6, R10)
    for (int i = 0; i < 40; i++) begin
      logic [4:0] b, phy, ra;
      logic [15:0] wd;
      strap = 5'($urandom);
      alt = 1'($urandom);
      b = alt ? {strap[4:3], 3'b000} : strap;
      phy = b + 5'($urandom % 10);
      ra = 5'($urandom % 12);
      wd = 16'($urandom);
      if ($urandom % 2 == 0) begin
        wr(phy, ra, wd); model_write(phy, ra, wd);
      end else begin
        rd_chk("R2", phy, ra);
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule